// File: doc/BRIEF.md
# Two-Deep UART Receive Buffer with Queued Frame Status

This block takes finished characters from a UART receive shift register and holds up to two of them until a host reads them. Each stored character carries its own status bits (stop-bit fault, lost data, parity fault), so a host always sees the status of the character it is about to read, not of whatever arrived last. The block raises a level-sensitive receive-complete flag and interrupt while unread characters remain, and empties itself when the receiver is switched off.

The inbound side is a valid/ready stream. The shift register offers a frame with `fr_valid`. The frame moves into the buffer on any rising clock edge where `fr_valid` and `fr_ready` are both high. While `fr_ready` is low, the source holds `fr_valid` and the payload steady; that held frame is the character waiting in the shift register. The source also pulses `start_seen` when it detects a new start bit. If that pulse arrives while the buffer is full and a frame is already held, data has been lost, and the block marks the held frame as having an overrun.

The host side is a simple register port. The host reads the status outputs first. It then pulses `rd_en`, which pops the oldest character into `rd_data` and moves the status outputs on to the next character.

Top module: `rx_frame_buffer`

## Requirements
- R1: `rxc` is high exactly when at least one unread character is stored. While the buffer is empty, `st_fe`, `st_dor` and `st_pe` read 0.
- R2: While `rx_en` is low, every stored character is discarded, `rxc` is 0 from the next edge on, `fr_ready` is 0, and offered frames are not stored.
- R3: `irq` is high for as long as `rxc_ie` and `rxc` are both high. It is a level, not a pulse.
- R4: The status outputs show the flags of the oldest unread character. Characters leave the buffer in arrival order, one per `rd_en` pulse.
- R5: `st_fe` for a character is 1 exactly when its `fr_stop` bit was 0. Any later stop bits never reach the block.
- R6: A `start_seen` pulse sets an overrun mark if `fr_valid` is high, `fr_ready` is low and two characters are stored. The mark is stored as `st_dor`=1 with the held frame when that frame enters the buffer. The transfer then clears the mark, so the following frame has `st_dor`=0.
- R7: Parity is checked when `par_mode[1]`=1. `par_mode[0]`=0 selects even parity, which gives an error when the XOR of the data bits differs from `fr_par`. `par_mode[0]`=1 selects odd parity, which gives an error when that XOR equals `fr_par`. When `par_mode[1]`=0, `st_pe` is always 0.
- R8: The error flags never drive `irq`. With `rxc_ie`=0, `irq` stays 0 even when a flagged character is stored.
- R9: An `rd_en` pulse on an empty buffer leaves `rd_data` unchanged and does not disturb the pointers, so later characters are read correctly.
- R10: A push and a pop in the same cycle leave the number of stored characters unchanged.
- R11: `rd_data` takes the popped character at the edge where `rd_en` is sampled high, and holds it until the next pop.
- R12: `fr_ready` is high exactly when `rx_en` is high and fewer than two characters are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| par_mode | input | 2 | [1] parity check on, [0] odd (1) or even (0) |
| fr_valid | input | 1 | Shift register offers a frame |
| fr_ready | output | 1 | Buffer can take the offered frame |
| fr_data | input | DATA_W | Received data bits |
| fr_stop | input | 1 | First stop bit as sampled |
| fr_par | input | 1 | Received parity bit |
| start_seen | input | 1 | Pulse: a new start bit was detected |
| rd_en | input | 1 | Host data read pulse (pop) |
| rd_data | output | DATA_W | Last popped character |
| rxc | output | 1 | Unread data present |
| irq | output | 1 | Receive-complete interrupt request |
| st_fe | output | 1 | Frame error of the oldest unread character |
| st_dor | output | 1 | Overrun mark of the oldest unread character |
| st_pe | output | 1 | Parity error of the oldest unread character |

## Verification
A wrong occupancy count or a misplaced pointer shows at the ports within one read. It appears as `rxc` or `fr_ready` at the wrong level, or as a character and its flags coming out of order. For that reason the scenarios read every character back and compare both the data and the status. A mark that stays set or clears too early shows on the `st_dor` of the first or second character read after the overrun. A flush that misses an entry shows as `rxc` high one cycle after `rx_en` drops.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef struct packed {
    logic fe;
    logic dor;
    logic pe;
  } rx_flags_t;
endpackage

// File: rtl/rxb_check.sv
module rxb_check #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              stop_bit,
  input  logic              par_bit,
  input  logic [1:0]        par_mode,
  output logic              fe,
  output logic              pe
);
  logic xsum;

  always_comb begin
    xsum = ^data;
    fe   = ~stop_bit;
    // bit1 enables checking, bit0 selects odd
    if (!par_mode[1])
      pe = 1'b0;
    else if (par_mode[0])
      pe = ~(xsum ^ par_bit);
    else
      pe = xsum ^ par_bit;
  end
endmodule

// File: rtl/rxb_ovr.sv
module rxb_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic in_valid,
  input  logic in_ready,
  input  logic start_seen,
  output logic ovr_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovr_pend <= 1'b0;
    else if (!rx_en)
      ovr_pend <= 1'b0;
    else if (in_valid && in_ready)
      ovr_pend <= 1'b0;
    else if (in_valid && !in_ready && start_seen)
      ovr_pend <= 1'b1;
  end

  // R6
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && in_valid && in_ready) |=> !ovr_pend);
endmodule

// File: rtl/rxb_store.sv
module rxb_store
  import rxb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  rx_flags_t         push_flags,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output rx_flags_t         head_flags,
  output logic              full,
  output logic              empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [DATA_W-1:0] mem_d [DEPTH];
  rx_flags_t         mem_f [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              do_push, do_pop;

  assign full    = (count == CMAX);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_d[g] <= '0;
          mem_f[g] <= '0;
        end else if (do_push && wr_ptr == PW'(g)) begin
          mem_d[g] <= push_data;
          mem_f[g] <= push_flags;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  assign head_data  = mem_d[rd_ptr];
  assign head_flags = mem_f[rd_ptr];

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CMAX);

  // R10
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && do_push && do_pop) |=> count == $past(count));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !push && pop && empty) |=> empty && $stable(rd_ptr));
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
  import rxb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rxc_ie,
  input  logic [1:0]        par_mode,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  logic [DATA_W-1:0] fr_data,
  input  logic              fr_stop,
  input  logic              fr_par,
  input  logic              start_seen,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rxc,
  output logic              irq,
  output logic              st_fe,
  output logic              st_dor,
  output logic              st_pe
);
  logic              full, empty, ovr_pend, push, pop, chk_fe, chk_pe;
  logic [DATA_W-1:0] head_data;
  rx_flags_t         head_flags, new_flags;

  assign fr_ready = rx_en && !full;
  assign push     = fr_valid && fr_ready;
  assign pop      = rd_en && rx_en;

  rxb_check #(.DATA_W(DATA_W)) u_check (
    .data(fr_data), .stop_bit(fr_stop), .par_bit(fr_par),
    .par_mode(par_mode), .fe(chk_fe), .pe(chk_pe)
  );

  rxb_ovr u_ovr (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(fr_valid),
    .in_ready(fr_ready), .start_seen(start_seen), .ovr_pend(ovr_pend)
  );

  always_comb begin
    new_flags.fe  = chk_fe;
    new_flags.dor = ovr_pend;
    new_flags.pe  = chk_pe;
  end

  rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(push),
    .push_data(fr_data), .push_flags(new_flags), .pop(pop),
    .head_data(head_data), .head_flags(head_flags),
    .full(full), .empty(empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (pop && !empty)
      rd_data <= head_data;
  end

  assign rxc    = !empty;
  assign irq    = rxc_ie && rxc;
  assign st_fe  = rxc && head_flags.fe;
  assign st_dor = rxc && head_flags.dor;
  assign st_pe  = rxc && head_flags.pe;

  // R2
  flush_rxc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rxc);

  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rxc) |=> $stable(rd_data));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rxc_ie && !empty));
endmodule

// File: tb/sim_rx_frame_buffer.sv
module sim_rx_frame_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, rxc_ie = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic       fr_valid = 1'b0, fr_stop = 1'b1, fr_par = 1'b0, start_seen = 1'b0;
  logic [7:0] fr_data = '0;
  logic       rd_en = 1'b0;
  logic       fr_ready, rxc, irq, st_fe, st_dor, st_pe;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_frame_buffer u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxc_ie(rxc_ie),
    .par_mode(par_mode), .fr_valid(fr_valid), .fr_ready(fr_ready),
    .fr_data(fr_data), .fr_stop(fr_stop), .fr_par(fr_par),
    .start_seen(start_seen), .rd_en(rd_en), .rd_data(rd_data),
    .rxc(rxc), .irq(irq), .st_fe(st_fe), .st_dor(st_dor), .st_pe(st_pe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // offer a frame and hold it until accepted
  task automatic push(input logic [7:0] d, input logic stp, input logic p);
    bit got;
    fr_data = d; fr_stop = stp; fr_par = p; fr_valid = 1'b1;
    do begin
      got = fr_ready;
      @(negedge clk);
    end while (!got);
    fr_valid = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rxc after reset", rxc, 0);
    chk("R1 flags empty", {st_fe, st_dor, st_pe}, 0);
    chk("R12 ready after enable", fr_ready, 1);
    chk("R3 irq reset", irq, 0);
  endtask

  task automatic t_order_and_fe();
    push(8'h3C, 1'b1, 1'b0);
    chk("R1 rxc one stored", rxc, 1);
    chk("R5 good stop", st_fe, 0);
    push(8'hA5, 1'b0, 1'b0);
    chk("R12 ready full", fr_ready, 0);
    rxc_ie = 1'b1; #1;
    chk("R3 irq level", irq, 1);
    @(negedge clk);
    chk("R3 irq held", irq, 1);
    rd();
    chk("R11 R4 first out", rd_data, 8'h3C);
    chk("R5 R4 next head fe", st_fe, 1);
    chk("R12 ready after pop", fr_ready, 1);
    rd();
    chk("R4 second out", rd_data, 8'hA5);
    chk("R1 rxc empty", rxc, 0);
    chk("R1 R3 irq drops", irq, 0);
    rxc_ie = 1'b0;
  endtask

  task automatic t_parity();
    par_mode = 2'b10;               // even: error when xor != bit
    push(8'h07, 1'b1, 1'b1);        // xor 1 == 1 ok
    chk("R7 even ok", st_pe, 0);
    rd();
    push(8'h07, 1'b1, 1'b0);
    chk("R7 even bad", st_pe, 1);
    chk("R8 irq with error ie off", irq, 0);
    rd();
    par_mode = 2'b11;               // odd: error when xor == bit
    push(8'h03, 1'b1, 1'b0);        // xor 0 == 0 bad
    chk("R7 odd bad", st_pe, 1);
    rd();
    push(8'h03, 1'b1, 1'b1);
    chk("R7 odd ok", st_pe, 0);
    rd();
    par_mode = 2'b01;
    push(8'h03, 1'b1, 1'b0);
    chk("R7 disabled", st_pe, 0);
    rd();
    par_mode = 2'b00;
  endtask

  task automatic t_overrun();
    push(8'h11, 1'b1, 1'b0);
    push(8'h22, 1'b1, 1'b0);
    fr_data = 8'h33; fr_stop = 1'b1; fr_valid = 1'b1;
    start_seen = 1'b1;
    @(negedge clk);
    start_seen = 1'b0;
    rd();                           // pop 11, held 33 enters next edge
    chk("R11 pop 11", rd_data, 8'h11);
    chk("R6 head 22 clean", st_dor, 0);
    @(negedge clk);
    fr_valid = 1'b0;
    rd();
    chk("R4 pop 22", rd_data, 8'h22);
    chk("R6 dor with frame", st_dor, 1);
    rd();
    chk("R4 pop 33", rd_data, 8'h33);
    push(8'h44, 1'b1, 1'b0);
    chk("R6 dor cleared", st_dor, 0);
    rd();
    // start bit while not full: no mark
    fr_data = 8'h55; fr_valid = 1'b1; start_seen = 1'b1;
    @(negedge clk);
    fr_valid = 1'b0; start_seen = 1'b0;
    chk("R6 no mark when room", st_dor, 0);
    rd();
  endtask

  task automatic t_empty_read();
    rd();
    chk("R9 hold on empty", rd_data, 8'h55);
    chk("R9 still empty", rxc, 0);
    push(8'h66, 1'b1, 1'b0);
    rd();
    chk("R9 pointers intact", rd_data, 8'h66);
  endtask

  task automatic t_push_pop();
    push(8'h77, 1'b1, 1'b0);
    fr_data = 8'h88; fr_stop = 1'b0; fr_valid = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    fr_valid = 1'b0; rd_en = 1'b0;
    chk("R10 pop data", rd_data, 8'h77);
    chk("R10 one left", {rxc, fr_ready}, 2'b11);
    chk("R10 head fe", st_fe, 1);
    rd();
    chk("R10 second", rd_data, 8'h88);
    chk("R10 empty", rxc, 0);
  endtask

  task automatic t_flush();
    push(8'h99, 1'b0, 1'b0);
    push(8'hAA, 1'b1, 1'b0);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R2 rxc flushed", rxc, 0);
    chk("R2 ready off", fr_ready, 0);
    chk("R2 flags cleared", {st_fe, st_dor, st_pe}, 0);
    fr_data = 8'hBB; fr_valid = 1'b1;
    @(negedge clk);
    fr_valid = 1'b0;
    rx_en = 1'b1;
    @(negedge clk);
    chk("R2 no store while off", rxc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rx_en = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_and_fe();
    t_parity();
    t_overrun();
    t_empty_read();
    t_push_pop();
    t_flush();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule